// File: doc/BRIEF.md
# Mid-Stop Resynchronising Serial Byte Receiver

This block recovers characters from one asynchronous serial input line. Each character is a low start bit, eight data bits sent least significant first, no parity and one high stop bit. The line first passes through a flop synchroniser. A free-running timebase then ticks sixteen times per bit period, at a rate set by a clock-divisor parameter. A frame engine walks each character on those ticks and hands out the assembled byte with a single-cycle strobe.

The block is built for long bursts with no gaps between characters. The engine goes back to hunting for a start bit in the same tick that it samples the stop bit at its centre. It does not wait for the nominal end of the stop bit, and it needs no high time before the next start. Each character therefore realigns the timing, and a clock mismatch of a few percent in either direction never builds up across a stream.

A separate line watcher counts how long the line holds one level. It flags a long quiet (high) period and a long break (low) period as level outputs.

Top module: `uart_rx_resync`

## Requirements
- R1: One clock after reset is applied, `valid_o`, `frame_err_o`, `idle_o` and `break_o` are all low.
- R2: A character of one low start bit, eight data bits (bit 0 sent first) and a high stop bit is delivered on `data_o`, with `valid_o` high for exactly one clock per character, raised when the stop bit is sampled at its centre.
- R3: A low pulse on the line that has ended by the centre of the nominal start bit (start re-checked after half a bit period) produces no character.
- R4: If the stop-bit sample is low, `frame_err_o` pulses in the same clock as `valid_o` and the received byte is still presented; `frame_err_o` is never high without `valid_o`.
- R5: A gapless stream whose bit period is about 3% shorter than the receiver's is decoded with every byte correct and no framing error. The start search resumes at the stop-bit centre and accepts a start with no preceding idle time.
- R6: A gapless stream whose bit period is about 3% longer than the receiver's is decoded with every byte correct and no framing error.
- R7: `idle_o` rises once the synchronised line has stayed high for more than 11 bit times (176 timebase ticks). It stays low before that, and it clears in the clock after the synchronised line falls.
- R8: `break_o` rises once the synchronised line has stayed low for at least 11 bit times. It stays low before that, and it clears in the clock after the synchronised line rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_i | input | 1 | Asynchronous serial line, high when idle |
| data_o | output | DATA_BITS | Last received byte |
| valid_o | output | 1 | One-clock strobe: `data_o` holds a new byte |
| frame_err_o | output | 1 | One-clock strobe with `valid_o` when the stop bit sampled low |
| idle_o | output | 1 | Line has been high for more than 11 bit times |
| break_o | output | 1 | Line has been low for at least 11 bit times |

## Verification
The bench builds the receiver with a divisor of 4 and the default sixteen-times timebase, so one bit lasts 64 clocks. At that size, gapless bursts of forty characters at 62 and 66 clocks per bit finish in a few tens of thousands of cycles. An engine that re-armed only at the end of the stop bit would slip by more than half a bit within such a burst. The 11-bit idle and break windows come to about 700 clocks, so both thresholds can be probed just below and just above their limits.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [1:0] {
      ST_HUNT  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_STOP  = 2'd3
   } rx_state_e;

   localparam int unsigned GAP_BITS_DEFAULT = 11;

endpackage

// File: rtl/rx_sync_chain.sv
module rx_sync_chain #(
   parameter int STAGES      = 2,
   parameter bit RESET_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] pipe_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) pipe_q[0] <= RESET_LEVEL;
               else     pipe_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) pipe_q[s] <= RESET_LEVEL;
               else     pipe_q[s] <= pipe_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst,
   output logic tick_o
);
   generate
      if (DIV == 1) begin : g_every_clock
         logic unused_rst;
         assign unused_rst = rst;
         assign tick_o     = 1'b1;
      end else begin : g_divider
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               cnt_q  <= '0;
               tick_o <= 1'b0;
            end else if (cnt_q == CW'(DIV - 1)) begin
               cnt_q  <= '0;
               tick_o <= 1'b1;
            end else begin
               cnt_q  <= cnt_q + CW'(1);
               tick_o <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
   import uart_rx_pkg::*;
#(
   parameter int DATA_BITS  = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 tick_i,
   input  logic                 rx_i,
   output logic [DATA_BITS-1:0] data_o,
   output logic                 valid_o,
   output logic                 ferr_o
);
   localparam int HALF = OVERSAMPLE / 2;
   localparam int OSW  = $clog2(OVERSAMPLE);
   localparam int BW   = $clog2(DATA_BITS + 1);

   rx_state_e            st_q;
   logic [OSW-1:0]       os_q;
   logic [BW-1:0]        bit_q;
   logic [DATA_BITS-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= ST_HUNT;
         os_q    <= '0;
         bit_q   <= '0;
         sh_q    <= '0;
         data_o  <= '0;
         valid_o <= 1'b0;
         ferr_o  <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         ferr_o  <= 1'b0;
         if (tick_i) begin
            unique case (st_q)
               ST_HUNT: begin
                  // a low level is a start: no idle time is demanded
                  if (!rx_i) begin
                     st_q <= ST_START;
                     os_q <= '0;
                  end
               end
               ST_START: begin
                  if (os_q == OSW'(HALF - 1)) begin
                     os_q  <= '0;
                     bit_q <= '0;
                     st_q  <= rx_i ? ST_HUNT : ST_DATA;
                  end else begin
                     os_q <= os_q + OSW'(1);
                  end
               end
               ST_DATA: begin
                  if (os_q == OSW'(OVERSAMPLE - 1)) begin
                     os_q <= '0;
                     sh_q <= {rx_i, sh_q[DATA_BITS-1:1]};
                     if (bit_q == BW'(DATA_BITS - 1)) st_q  <= ST_STOP;
                     else                             bit_q <= bit_q + BW'(1);
                  end else begin
                     os_q <= os_q + OSW'(1);
                  end
               end
               ST_STOP: begin
                  if (os_q == OSW'(OVERSAMPLE - 1)) begin
                     // stop centre: deliver and re-arm the hunt at once
                     data_o  <= sh_q;
                     valid_o <= 1'b1;
                     ferr_o  <= ~rx_i;
                     os_q    <= '0;
                     st_q    <= ST_HUNT;
                  end else begin
                     os_q <= os_q + OSW'(1);
                  end
               end
               default: st_q <= ST_HUNT;
            endcase
         end
      end
   end
endmodule

// File: rtl/rx_line_watch.sv
module rx_line_watch #(
   parameter int OVERSAMPLE = 16,
   parameter int GAP_BITS   = 11
) (
   input  logic clk,
   input  logic rst,
   input  logic tick_i,
   input  logic rx_i,
   output logic idle_o,
   output logic break_o
);
   localparam int BRK_T  = GAP_BITS * OVERSAMPLE;
   localparam int IDLE_T = BRK_T + 1;
   localparam int CW     = $clog2(IDLE_T + 1);

   logic          rx_q;
   logic [CW-1:0] run_q;
   logic          rise, fall;

   assign rise = rx_i & ~rx_q;
   assign fall = ~rx_i & rx_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         rx_q    <= 1'b1;
         run_q   <= '0;
         idle_o  <= 1'b0;
         break_o <= 1'b0;
      end else begin
         rx_q <= rx_i;

         if (rise || fall)                               run_q <= '0;
         else if (tick_i && run_q != CW'(IDLE_T))        run_q <= run_q + CW'(1);

         if (fall)                                       idle_o <= 1'b0;
         else if (rx_q && run_q == CW'(IDLE_T))          idle_o <= 1'b1;

         if (rise)                                       break_o <= 1'b0;
         else if (!rx_q && run_q >= CW'(BRK_T))          break_o <= 1'b1;
      end
   end
endmodule

// File: rtl/uart_rx_resync.sv
module uart_rx_resync
   import uart_rx_pkg::*;
#(
   parameter int CLKS_PER_BIT_X16 = 4,
   parameter int DATA_BITS        = 8,
   parameter int OVERSAMPLE       = 16,
   parameter int SYNC_STAGES      = 2,
   parameter int GAP_BITS         = GAP_BITS_DEFAULT
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 rx_i,
   output logic [DATA_BITS-1:0] data_o,
   output logic                 valid_o,
   output logic                 frame_err_o,
   output logic                 idle_o,
   output logic                 break_o
);
   generate
      if (CLKS_PER_BIT_X16 < 1) begin : g_bad_div
         $error("CLKS_PER_BIT_X16 must be at least 1");
      end
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("OVERSAMPLE must be even and at least 4");
      end
      if (DATA_BITS < 5 || DATA_BITS > 9) begin : g_bad_width
         $error("DATA_BITS must lie between 5 and 9");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (GAP_BITS < 2) begin : g_bad_gap
         $error("GAP_BITS must be at least 2");
      end
   endgenerate

   logic rx_s;
   logic tick;

   rx_sync_chain #(.STAGES(SYNC_STAGES), .RESET_LEVEL(1'b1)) u_sync (
      .clk (clk), .rst (rst), .d_i (rx_i), .q_o (rx_s)
   );

   rx_tick_gen #(.DIV(CLKS_PER_BIT_X16)) u_tick (
      .clk (clk), .rst (rst), .tick_o (tick)
   );

   rx_frame_fsm #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_frame (
      .clk (clk), .rst (rst), .tick_i (tick), .rx_i (rx_s),
      .data_o (data_o), .valid_o (valid_o), .ferr_o (frame_err_o)
   );

   rx_line_watch #(.OVERSAMPLE(OVERSAMPLE), .GAP_BITS(GAP_BITS)) u_watch (
      .clk (clk), .rst (rst), .tick_i (tick), .rx_i (rx_s),
      .idle_o (idle_o), .break_o (break_o)
   );
endmodule

// File: rtl/uart_rx_resync_chk.sv
module uart_rx_resync_chk (
   input logic clk,
   input logic rst,
   input logic rx_s,
   input logic valid_o,
   input logic frame_err_o,
   input logic idle_o,
   input logic break_o
);
   logic rst_d = 1'b0;
   always_ff @(posedge clk) rst_d <= rst;

   // R1: outputs quiet one clock after reset
   always @(posedge clk) begin
      if (rst_d) begin
         p_reset_quiet_r1: assert (!valid_o && !frame_err_o && !idle_o && !break_o)
            else $error("outputs not quiet after reset");
      end
   end

   p_valid_single_r2: assert property (@(posedge clk) disable iff (rst)
      valid_o |=> !valid_o);

   p_ferr_with_valid_r4: assert property (@(posedge clk) disable iff (rst)
      frame_err_o |-> valid_o);

   p_idle_clear_r7: assert property (@(posedge clk) disable iff (rst)
      $fell(rx_s) |=> !idle_o);

   p_idle_needs_high_r7: assert property (@(posedge clk) disable iff (rst)
      idle_o |-> !break_o);

   p_break_clear_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(rx_s) |=> !break_o);
endmodule

bind uart_rx_resync uart_rx_resync_chk u_chk (
   .clk (clk), .rst (rst), .rx_s (rx_s), .valid_o (valid_o),
   .frame_err_o (frame_err_o), .idle_o (idle_o), .break_o (break_o)
);

// File: tb/uart_rx_resync_test.sv
module uart_rx_resync_test;
   localparam int X16 = 4;
   localparam int BIT = 64;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       rx  = 1'b1;
   logic [7:0] data;
   logic       valid, ferr, idle, brk;

   always #4 clk = ~clk;

   uart_rx_resync #(.CLKS_PER_BIT_X16(X16)) uut (
      .clk (clk), .rst (rst), .rx_i (rx), .data_o (data), .valid_o (valid),
      .frame_err_o (ferr), .idle_o (idle), .break_o (brk)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [7:0] log_d [128];
   logic       log_f [128];
   int         log_n = 0;
   logic       valid_prev = 1'b0;

   // vector: byte, stop level, clocks per bit
   localparam logic [16:0] VEC [8] = '{
      {8'hA5, 1'b1, 8'd64}, {8'h00, 1'b1, 8'd64}, {8'hFF, 1'b1, 8'd64},
      {8'h01, 1'b1, 8'd63}, {8'h80, 1'b1, 8'd65}, {8'h3C, 1'b0, 8'd64},
      {8'h5A, 1'b1, 8'd62}, {8'hC3, 1'b1, 8'd66}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   always @(negedge clk) begin
      if (!rst) begin
         if (valid && valid_prev) check(1'b0, "R2 strobe width", 2, 1);
         if (valid && log_n < 128) begin
            log_d[log_n] = data;
            log_f[log_n] = ferr;
            log_n++;
         end
         if (ferr && !valid) check(1'b0, "R4 ferr without valid", 0, 1);
      end
      valid_prev = valid;
   end

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] b, input logic stop, input int per);
      rx = 1'b0;
      wait_clks(per);
      for (int i = 0; i < 8; i++) begin
         rx = b[i];
         wait_clks(per);
      end
      rx = stop;
      wait_clks(per);
      rx = 1'b1;
   endtask

   task automatic burst(input int per, input string req);
      int n0;
      int bad;
      n0  = log_n;
      bad = 0;
      for (int i = 0; i < 40; i++) send(8'((i * 37 + 5) & 8'hFF), 1'b1, per);
      wait_clks(100);
      check(log_n == n0 + 40, req, log_n - n0, 40);
      for (int i = 0; i < 40; i++) begin
         if (n0 + i < 128) begin
            if (log_d[n0 + i] !== 8'((i * 37 + 5) & 8'hFF) || log_f[n0 + i] !== 1'b0) bad++;
         end
      end
      check(bad == 0, req, bad, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R2 watchdog actual=timeout expected=completion");
         report();
         $finish;
      end
   end

   initial begin
      int n0;
      wait_clks(5);
      // R1: reset state
      check(valid === 1'b0 && ferr === 1'b0, "R1 strobes", {valid, ferr}, 0);
      check(idle === 1'b0 && brk === 1'b0, "R1 levels", {idle, brk}, 0);
      rst = 1'b0;

      // R7: idle threshold below and above
      wait_clks(300);
      check(idle === 1'b0, "R7 idle early", idle, 0);
      wait_clks(500);
      check(idle === 1'b1, "R7 idle raised", idle, 1);

      // R7 clear on start edge, R3 short low pulse rejected
      n0 = log_n;
      rx = 1'b0;
      wait_clks(10);
      check(idle === 1'b0, "R7 idle cleared", idle, 0);
      rx = 1'b1;
      wait_clks(700);
      check(log_n == n0, "R3 glitch", log_n - n0, 0);

      // R2/R4: vector table
      for (int v = 0; v < 8; v++) begin
         n0 = log_n;
         send(VEC[v][16:9], VEC[v][8], int'(VEC[v][7:0]));
         wait_clks(100);
         check(log_n == n0 + 1, "R2 count", log_n - n0, 1);
         check(log_d[n0] === VEC[v][16:9], VEC[v][8] ? "R2 data" : "R4 data",
               log_d[n0], VEC[v][16:9]);
         check(log_f[n0] === ~VEC[v][8], "R4 frame error", log_f[n0], ~VEC[v][8]);
      end

      // R5 fast gapless, R6 slow gapless
      log_n = 0;
      burst(62, "R5 fast burst");
      wait_clks(200);
      log_n = 0;
      burst(66, "R6 slow burst");
      wait_clks(200);

      // R8: break threshold and release
      rx = 1'b0;
      wait_clks(650);
      check(brk === 1'b0, "R8 break early", brk, 0);
      wait_clks(100);
      check(brk === 1'b1, "R8 break raised", brk, 1);
      check(idle === 1'b0, "R7 idle during break", idle, 0);
      rx = 1'b1;
      wait_clks(5);
      check(brk === 1'b0, "R8 break cleared", brk, 0);

      // recovery after break
      wait_clks(800);
      n0 = log_n;
      send(8'h96, 1'b1, BIT);
      wait_clks(100);
      check(log_n == n0 + 1 && log_d[n0] === 8'h96, "R2 after break", log_d[n0], 8'h96);

      done = 1'b1;
      report();
      $finish;
   end
endmodule